// File: doc/BRIEF.md
# Address-Filtering UART Receiver

This block is the receive half of an asynchronous serial port. It oversamples the serial input line, assembles characters of 5 to 9 data bits with optional parity, checks the stop bit and places each character in a four-entry receive queue. Each queue entry is 11 bits wide. Bits [8:0] hold the data, zero-extended above the programmed length. Bit 9 is the parity-error flag and bit 10 is the framing-error flag. The queue drains through a valid/ready stream port. The oldest entry is presented while `m_valid_o` is high, it is removed on a cycle with `m_valid_o` and `m_ready_i` both high, and it holds steady while the consumer stalls.

In multidrop operation, characters are 9 bits long and the ninth bit marks an address character. A gate decides which characters reach the queue. In the strict policy, only an address matching one of two programmed values opens the gate. In the loose policy, any address opens it. A command strobe carries four actions in one write: enable reception, reset the character machine, empty the queue, and lock the queue. Resetting the machine also unlocks the queue, and this unlock wins over a lock in the same write. Sticky flags report framing, parity and overrun. A status-clear pulse resets these flags but leaves the not-empty flag alone.

The sample tick comes from an external baud generator. With `os16_i` high, each tick is one sixteenth of a bit time. With `os16_i` low, each tick marks a rising edge of the serial clock, and one bit is sampled per tick.

Top module: `addr_uart_rx`

## Requirements
- R1: In 16x mode, a low level on `rxd_i` counts as a start bit only if it is still low at the eighth tick after it is first seen. A shorter low pulse produces no character.
- R2: Data bits arrive LSB first and are sampled at mid-bit. `len_i` 0..4 selects 5..9 data bits, and values above 4 mean 9. Entry bits [8:0] hold the data, with unused upper bits zero.
- R3: With `par_en_i` high, a parity bit follows the data. `par_odd_i`=0 selects even parity and 1 selects odd. A mismatch sets entry bit 9 and `parity_err_o`.
- R4: A stop bit sampled as 0 sets entry bit 10 and `frame_err_o`. The character is still queued.
- R5: A start bit that follows a stop bit shortened to just past mid-bit, with no idle time between them, is received correctly.
- R6: With `os16_i` low, each tick samples one bit. A low sample while idle is taken as the start bit, and the next tick samples data bit 0.
- R7: With `mode_i`=2 (strict), a character with bit 8 set is an address. If its low 8 bits equal `addr0_i` or `addr1_i`, it is queued and opens the gate. Otherwise it is dropped and closes the gate. Non-address characters are queued only while the gate is open. The gate is closed after reset.
- R8: With `mode_i`=1 (loose), every address character is queued and opens the gate. With `mode_i`=0 or 3, every character is queued.
- R9: `cmd_i` bits are applied when `cmd_we_i` is high: [0] enables reception, [1] resets the character machine and unlocks, [2] empties the queue, [3] locks. No character is received before the enable command, and none is queued while locked. Bits [1] and [3] together leave the queue unlocked.
- R10: Locking and unlocking do not move the queue write position. Emptying the queue discards all entries, and the next character becomes the head.
- R11: The usable depth is `depth_i` (1..4; 0 means 1, above 4 means 4). A character completing while the queue holds that many entries is dropped and sets `overrun_o`. The stored entries are kept.
- R12: A `stat_clr_i` pulse clears `overrun_o`, `frame_err_o` and `parity_err_o`. It does not change `nempty_o`.
- R13: After reset, `m_valid_o`, `nempty_o`, all status flags, `enabled_o` and `locked_o` are 0. While `m_valid_o` is high and `m_ready_i` is low, `m_data_o` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Sample tick (16x rate or serial-clock edge) |
| os16_i | input | 1 | 1 = 16x oversampling, 0 = 1x clocking |
| rxd_i | input | 1 | Serial input, idle high |
| len_i | input | 3 | Data length code, 5 + value bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| mode_i | input | 2 | 0 off, 1 loose, 2 strict address policy |
| addr0_i | input | 8 | First compare address |
| addr1_i | input | 8 | Second compare address |
| cmd_we_i | input | 1 | Command strobe |
| cmd_i | input | 4 | Command bits (enable, reset machine, empty, lock) |
| stat_clr_i | input | 1 | Clear sticky status flags |
| depth_i | input | 3 | Usable queue depth |
| m_valid_o | output | 1 | Stream entry valid |
| m_ready_i | input | 1 | Stream consumer ready |
| m_data_o | output | 11 | Stream entry {frame, parity, data} |
| nempty_o | output | 1 | Queue not empty |
| overrun_o | output | 1 | Sticky overrun |
| frame_err_o | output | 1 | Sticky framing error |
| parity_err_o | output | 1 | Sticky parity error |
| enabled_o | output | 1 | Reception enabled |
| locked_o | output | 1 | Queue locked |
| gate_open_o | output | 1 | Address gate open |

## Verification
The embedded assertions check, on every cycle, these properties: a completed stop sample always yields a character; the queue never accepts a write beyond its limit; the write position stays still without a write or an empty command; the stream data holds while stalled; the unlock from a machine reset beats a simultaneous lock; and a status clear resets the sticky flags. Only the bench scenarios can show the rest. These include bit order and length, parity and stop checking on real waveforms, false-start rejection, back-to-back characters after a shortened stop bit, 1x clocking, and the address-gate sequences under both policies. They also include overrun, which drops the new character while keeping the older entries.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  localparam int DATA_W  = 9;
  localparam int ENTRY_W = DATA_W + 2;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} rx_state_t;

  typedef struct packed {
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam logic [1:0] MD_LOOSE  = 2'd1;
  localparam logic [1:0] MD_STRICT = 2'd2;
endpackage

// File: rtl/rxu_framer.sv
module rxu_framer
  import rxu_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  logic      abort_i,
  input  logic      os16_i,
  input  logic      tick_i,
  input  logic      rxd_i,
  input  logic [2:0] len_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  output logic      done_o,
  output rx_entry_t ent_o
);
  localparam int PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] MID  = PH_W'(OSR/2 - 1);
  localparam logic [PH_W-1:0] LAST = PH_W'(OSR - 1);

  rx_state_t         st;
  logic [PH_W-1:0]   ph;
  logic [3:0]        bitn;
  logic [3:0]        nbits;
  logic [DATA_W-1:0] shreg;
  logic              par_acc, perr_r, samp;

  always_comb begin
    nbits = (len_i >= 3'd4) ? 4'd9 : (4'd5 + {1'b0, len_i});
    samp  = tick_i && (os16_i ? (ph == LAST) : 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= '0; bitn <= '0; shreg <= '0;
      par_acc <= 1'b0; perr_r <= 1'b0; done_o <= 1'b0; ent_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (abort_i || !en_i) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE: if (tick_i && !rxd_i) begin
            ph <= '0; bitn <= '0; shreg <= '0; par_acc <= 1'b0; perr_r <= 1'b0;
            st <= os16_i ? ST_START : ST_DATA;
          end
          ST_START: if (tick_i) begin
            if (ph == MID) begin
              ph <= '0;
              st <= rxd_i ? ST_IDLE : ST_DATA;
            end else ph <= ph + 1'b1;
          end
          ST_DATA: begin
            if (tick_i) ph <= ph + 1'b1;
            if (samp) begin
              shreg[bitn] <= rxd_i;
              par_acc     <= par_acc ^ rxd_i;
              bitn        <= bitn + 1'b1;
              if (bitn == nbits - 4'd1) st <= par_en_i ? ST_PAR : ST_STOP;
            end
          end
          ST_PAR: begin
            if (tick_i) ph <= ph + 1'b1;
            if (samp) begin
              perr_r <= ((par_acc ^ rxd_i) != par_odd_i);
              st     <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (tick_i) ph <= ph + 1'b1;
            if (samp) begin
              done_o <= 1'b1;
              ent_o  <= '{ferr: ~rxd_i, perr: par_en_i & perr_r, data: shreg};
              st     <= ST_IDLE;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assert_stop_yields_char_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && samp && en_i && !abort_i) |=> done_o);
endmodule

// File: rtl/rxu_gate.sv
module rxu_gate
  import rxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we_i,
  input  logic [3:0]        cmd_i,
  input  logic [1:0]        mode_i,
  input  logic [7:0]        addr0_i,
  input  logic [7:0]        addr1_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              store_o,
  output logic              enabled_o,
  output logic              locked_o,
  output logic              open_o,
  output logic              abort_o,
  output logic              flush_o
);
  logic filt, is_addr, match, pass;

  always_comb begin
    filt    = (mode_i == MD_LOOSE) || (mode_i == MD_STRICT);
    is_addr = filt && data_i[DATA_W-1];
    match   = (data_i[7:0] == addr0_i) || (data_i[7:0] == addr1_i);
    if (!filt)        pass = 1'b1;
    else if (is_addr) pass = (mode_i == MD_LOOSE) ? 1'b1 : match;
    else              pass = open_o;
    store_o = done_i && enabled_o && !locked_o && pass;
    abort_o = cmd_we_i && cmd_i[1];
    flush_o = cmd_we_i && cmd_i[2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enabled_o <= 1'b0; locked_o <= 1'b0; open_o <= 1'b0;
    end else begin
      if (cmd_we_i && cmd_i[0]) enabled_o <= 1'b1;
      if (cmd_we_i && cmd_i[1])      locked_o <= 1'b0;
      else if (cmd_we_i && cmd_i[3]) locked_o <= 1'b1;
      if (done_i && is_addr) open_o <= pass;
    end
  end

  assert_unlock_beats_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && cmd_i[1]) |=> !locked_o);
  assert_lock_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && cmd_i[3] && !cmd_i[1]) |=> locked_o);
endmodule

// File: rtl/rxu_fifo.sv
module rxu_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 11,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          flush_i,
  input  logic [CW-1:0] depth_i,
  output logic          full_o,
  output logic          m_valid_o,
  input  logic          m_ready_i,
  output logic [W-1:0]  m_data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count, lim;
  logic          pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (depth_i == '0)                lim = CW'(1);
    else if (depth_i > CW'(DEPTH))    lim = CW'(DEPTH);
    else                              lim = depth_i;
    full_o    = (count >= lim);
    m_valid_o = (count != '0);
    m_data_o  = mem[rptr];
    pop       = m_valid_o && m_ready_i;
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (push_i) wptr <= nxt(wptr);
      if (pop)    rptr <= nxt(rptr);
      case ({push_i, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  assert_wptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !flush_i) |=> $stable(wptr));
  assert_stall_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i && !flush_i) |=> (m_valid_o && $stable(m_data_o)));
endmodule

// File: rtl/addr_uart_rx.sv
module addr_uart_rx
  import rxu_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               os16_i,
  input  logic               rxd_i,
  input  logic [2:0]         len_i,
  input  logic               par_en_i,
  input  logic               par_odd_i,
  input  logic [1:0]         mode_i,
  input  logic [7:0]         addr0_i,
  input  logic [7:0]         addr1_i,
  input  logic               cmd_we_i,
  input  logic [3:0]         cmd_i,
  input  logic               stat_clr_i,
  input  logic [CNT_W-1:0]   depth_i,
  output logic               m_valid_o,
  input  logic               m_ready_i,
  output logic [ENTRY_W-1:0] m_data_o,
  output logic               nempty_o,
  output logic               overrun_o,
  output logic               frame_err_o,
  output logic               parity_err_o,
  output logic               enabled_o,
  output logic               locked_o,
  output logic               gate_open_o
);
  logic      done, store, abort, flush, full, wr, ovr_set;
  rx_entry_t ent;

  rxu_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .en_i(enabled_o), .abort_i(abort), .os16_i(os16_i),
    .tick_i(tick_i), .rxd_i(rxd_i), .len_i(len_i), .par_en_i(par_en_i),
    .par_odd_i(par_odd_i), .done_o(done), .ent_o(ent));

  rxu_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cmd_we_i(cmd_we_i), .cmd_i(cmd_i), .mode_i(mode_i),
    .addr0_i(addr0_i), .addr1_i(addr1_i), .done_i(done), .data_i(ent.data),
    .store_o(store), .enabled_o(enabled_o), .locked_o(locked_o), .open_o(gate_open_o),
    .abort_o(abort), .flush_o(flush));

  assign wr      = store && !full;
  assign ovr_set = store && full;

  rxu_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(wr), .din_i(ent), .flush_i(flush),
    .depth_i(depth_i), .full_o(full), .m_valid_o(m_valid_o), .m_ready_i(m_ready_i),
    .m_data_o(m_data_o));

  assign nempty_o = m_valid_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overrun_o <= 1'b0; frame_err_o <= 1'b0; parity_err_o <= 1'b0;
    end else begin
      if (stat_clr_i) begin
        overrun_o <= 1'b0; frame_err_o <= 1'b0; parity_err_o <= 1'b0;
      end
      if (ovr_set)          overrun_o    <= 1'b1;
      if (wr && ent.ferr)   frame_err_o  <= 1'b1;
      if (wr && ent.perr)   parity_err_o <= 1'b1;
    end
  end

  assert_status_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_i && !store) |=> (!overrun_o && !frame_err_o && !parity_err_o));
endmodule

// File: tb/sim_addr_uart_rx.sv
module sim_addr_uart_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, os16 = 1'b1, rxd = 1'b1;
  logic [2:0] len = 3'd3, depth = 3'd4;
  logic par_en = 1'b0, par_odd = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] addr0 = 8'h12, addr1 = 8'h34;
  logic cmd_we = 1'b0, stat_clr = 1'b0, m_ready = 1'b0;
  logic [3:0] cmd = 4'd0;
  logic m_valid, nempty, overrun, ferr, perr, enabled, locked, gopen;
  logic [10:0] m_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  addr_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .os16_i(os16), .rxd_i(rxd), .len_i(len),
    .par_en_i(par_en), .par_odd_i(par_odd), .mode_i(mode), .addr0_i(addr0),
    .addr1_i(addr1), .cmd_we_i(cmd_we), .cmd_i(cmd), .stat_clr_i(stat_clr),
    .depth_i(depth), .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data),
    .nempty_o(nempty), .overrun_o(overrun), .frame_err_o(ferr), .parity_err_o(perr),
    .enabled_o(enabled), .locked_o(locked), .gate_open_o(gopen));

  // {len, par_en, par_odd, flip_parity, stop, data[8:0], expected[10:0]}
  localparam logic [26:0] VEC [7] = '{
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0A5, 11'h0A5},
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h013, 11'h013},
    {3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 9'h1C3, 11'h1C3},
    {3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 9'h037, 11'h037},
    {3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 9'h081, 11'h281},
    {3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 9'h055, 11'h455},
    {3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 9'h02A, 11'h02A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send(input logic [8:0] d, input logic flip, input logic stopv,
                      input int stop_len, input int idle);
    int bt = os16 ? 16 : 1;
    int nb = (len >= 3'd4) ? 9 : 5 + int'(len);
    logic p = 1'b0;
    hold(1'b0, bt);
    for (int i = 0; i < nb; i++) begin
      hold(d[i], bt);
      p ^= d[i];
    end
    if (par_en) hold(p ^ par_odd ^ flip, bt);
    hold(stopv, stop_len);
    hold(1'b1, idle);
  endtask

  task automatic sendc(input logic [8:0] d);
    send(d, 1'b0, 1'b1, os16 ? 16 : 1, 24);
  endtask

  task automatic do_cmd(input logic [3:0] v);
    cmd_we = 1'b1; cmd = v;
    @(posedge clk); #1;
    cmd_we = 1'b0; cmd = 4'd0;
    @(posedge clk); #1;
  endtask

  task automatic pop_expect(input string req, input logic [10:0] exp);
    @(negedge clk);
    chk({req, " valid"}, 32'(m_valid), 32'd1);
    chk({req, " data"}, 32'(m_data), 32'(exp));
    @(posedge clk); #1; m_ready = 1'b1;
    @(posedge clk); #1; m_ready = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    chk(req, 32'(m_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 reset valid", 32'(m_valid), 0);
    chk("R13 reset flags", {nempty, overrun, ferr, perr, enabled, locked}, 0);
    @(posedge clk); #1;
    // R9 not enabled: nothing received
    sendc(9'h05A);
    expect_empty("R9 disabled drop");
    do_cmd(4'b0001);
    chk("R9 enabled", 32'(enabled), 1);

    // table walk: R2 R3 R4
    foreach (VEC[i]) begin
      len = VEC[i][26:24]; par_en = VEC[i][23]; par_odd = VEC[i][22];
      send(VEC[i][19:11], VEC[i][21], VEC[i][20], 16, 30);
      pop_expect($sformatf("R2/R3/R4 vector %0d", i), VEC[i][10:0]);
    end
    chk("R4 frame status", 32'(ferr), 1);
    chk("R3 parity status", 32'(perr), 1);
    len = 3'd3; par_en = 1'b0; par_odd = 1'b0;

    // R1 false start
    hold(1'b0, 4); hold(1'b1, 40);
    expect_empty("R1 glitch rejected");

    // R5 shortened stop, next start immediately
    send(9'h0C6, 1'b0, 1'b1, 10, 0);
    sendc(9'h039);
    pop_expect("R5 first", 11'h0C6);
    pop_expect("R5 second", 11'h039);

    // R6 1x clocking
    os16 = 1'b0;
    sendc(9'h03C);
    sendc(9'h0E1);
    pop_expect("R6 first", 11'h03C);
    pop_expect("R6 second", 11'h0E1);
    os16 = 1'b1;

    // R13 stall hold
    sendc(9'h011); sendc(9'h022);
    @(negedge clk); chk("R13 stalled head", 32'(m_data), 32'h011);
    repeat (5) @(posedge clk);
    @(negedge clk); chk("R13 stalled hold", 32'(m_data), 32'h011);
    pop_expect("R13 pop1", 11'h011);
    pop_expect("R13 pop2", 11'h022);

    // R11 overrun with depth 2, then R12 status clear
    depth = 3'd2;
    sendc(9'h0A1); sendc(9'h0A2); sendc(9'h0A3);
    @(negedge clk); chk("R11 overrun set", 32'(overrun), 1);
    pop_expect("R11 keep first", 11'h0A1);
    @(posedge clk); #1; stat_clr = 1'b1; @(posedge clk); #1; stat_clr = 1'b0;
    @(negedge clk);
    chk("R12 flags cleared", {overrun, ferr, perr}, 0);
    chk("R12 nempty kept", 32'(nempty), 1);
    pop_expect("R11 keep second", 11'h0A2);
    expect_empty("R11 third dropped");
    depth = 3'd4;

    // R9 lock / unlock priority, R10 write position kept
    sendc(9'h0B1);
    do_cmd(4'b1000);
    chk("R9 locked", 32'(locked), 1);
    sendc(9'h0B2);
    do_cmd(4'b1010);
    chk("R9 unlock wins", 32'(locked), 0);
    sendc(9'h0B3);
    pop_expect("R10 before lock", 11'h0B1);
    pop_expect("R10 after unlock", 11'h0B3);
    expect_empty("R9 locked char dropped");

    // R10 flush
    sendc(9'h0C1); sendc(9'h0C2);
    do_cmd(4'b0100);
    expect_empty("R10 flushed");
    sendc(9'h0C3);
    pop_expect("R10 new head", 11'h0C3);

    // R7 strict address policy
    len = 3'd4; mode = 2'd2;
    sendc(9'h055);
    sendc(9'h177);
    chk("R7 closed on mismatch", 32'(gopen), 0);
    sendc(9'h134);
    chk("R7 open on match", 32'(gopen), 1);
    sendc(9'h066);
    sendc(9'h199);
    sendc(9'h011);
    pop_expect("R7 matched address", 11'h134);
    pop_expect("R7 data while open", 11'h066);
    expect_empty("R7 dropped while closed");

    // R8 loose address policy
    mode = 2'd1;
    sendc(9'h1AB);
    sendc(9'h022);
    pop_expect("R8 any address", 11'h1AB);
    pop_expect("R8 data after", 11'h022);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule